// File: doc/BRIEF.md
# Write-Through Data Cache with Store Queue

This block is a direct-mapped data cache that sits between a processor load/store port and a lower-level memory. Loads that find their line present and tagged correctly return data one cycle after acceptance. Loads that miss fetch the whole line from memory, install it, and then return the requested word. The cache keeps no dirty state: every store is forwarded to memory, and a store also patches the cached word when its line is already resident. A store to a line that is absent is never installed in the cache.

Stores are not written to memory directly. They go into a small first-in first-out store queue, so the processor can move on while memory is busy. The queue drains one entry per write handshake. A load miss may start its line fetch while older stores are still waiting, but only if none of the waiting stores falls in the same line. Otherwise the fetch waits until every such store has left the queue. While a miss is being serviced the processor port is held off.

Addresses are word addresses. The low address bits pick the word in a line, the next bits pick the set, and the remaining bits form the tag.

Top module: `wt_dcache`

## Requirements
- R1: After reset, every line is invalid and the store queue is empty. No memory write or line fetch is pending, `req_ready_o` is 1, and the first load to any address misses.
- R2: A load counts as a hit only when the selected set is valid and its stored tag equals the tag field of the address. A hit raises `rsp_valid_o` for one cycle, one cycle after acceptance, with no line fetch. A load whose tag differs from the resident one misses.
- R3: A load miss requests the line address (word address shifted right by log2 of the line length) on `mem_rd_line_o`. The full line returned on `mem_fill_data_i` (word k at bits k*DATA_W upward) is written into the set together with its tag and valid bit. The requested word appears on `rsp_rdata_o` one cycle after the fill beat, and later loads to any word of that line hit.
- R4: Every accepted store leaves on the memory write port exactly once, in acceptance order, with its own address, data and byte enables.
- R5: A store that hits merges its data into the cached word under its byte enables, where enable bit i covers data bits 8i+7 down to 8i. A following load to that word returns the merged value without a fetch.
- R6: A store that misses does not install its line. A later load to that line misses and returns the stored value from memory.
- R7: The store queue holds 4 entries. While it is full, a store request sees `req_ready_o` low until an entry drains.
- R8: A load miss whose line matches no queued store issues its fetch even while older stores to other lines remain queued.
- R9: No line fetch is requested while any queued store targets the same line. The fetch is issued once those stores have drained, so the load returns the stored data.
- R10: `mem_rd_valid_o` and `mem_wr_valid_o`, once raised, stay high with an unchanged payload until their ready input is seen high.
- R11: From a load miss until its response, `req_ready_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Processor request present |
| req_write_i | input | 1 | 1 for store, 0 for load |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Store data |
| req_be_i | input | DATA_W/8 | Store byte enables |
| req_ready_o | output | 1 | Request accepted on this edge when valid |
| rsp_valid_o | output | 1 | Load data valid (one-cycle pulse) |
| rsp_rdata_o | output | DATA_W | Load data |
| mem_rd_valid_o | output | 1 | Line fetch request |
| mem_rd_line_o | output | ADDR_W-log2(LINE_WORDS) | Line address to fetch |
| mem_rd_ready_i | input | 1 | Memory accepts the fetch request |
| mem_fill_valid_i | input | 1 | Line data returned (one beat) |
| mem_fill_data_i | input | LINE_WORDS*DATA_W | Full line contents |
| mem_wr_valid_o | output | 1 | Store queue head offered to memory |
| mem_wr_addr_o | output | ADDR_W | Store word address |
| mem_wr_data_o | output | DATA_W | Store data |
| mem_wr_be_o | output | DATA_W/8 | Store byte enables |
| mem_wr_ready_i | input | 1 | Memory accepts the store |

## Verification
A load hit answers on the first falling edge after its accepting rising edge. A miss answers on the first falling edge after the rising edge that consumes the fill beat. A store shows up at the head of the memory write port on the falling edge after acceptance when the queue was empty. The bench drives every input and samples every output on falling edges. It decides handshakes by comparing the valid it sees with the ready it has just driven for the coming rising edge. Latencies are counted in whole cycles from acceptance, so a hit is checked for zero extra cycles and for an unchanged fetch count. Memory-side ordering is checked at the moment each handshake is committed, against a queue of stores recorded at their acceptance edges.

// File: rtl/wt_dcache_pkg.sv
`timescale 1ns/1ps
package wt_dcache_pkg;

    // Controller phases of the cache
    typedef enum logic [1:0] {
        CTL_IDLE = 2'd0,   // accepting requests
        CTL_MISS = 2'd1,   // waiting to issue (or issuing) the line fetch
        CTL_FILL = 2'd2    // fetch accepted, waiting for the line beat
    } ctl_state_e;

endpackage

// File: rtl/wt_dcache_wbuf.sv
`timescale 1ns/1ps
// Store queue: FIFO of word stores with a per-entry line-address probe.
// DEPTH must be a power of two and at least 2.
module wt_dcache_wbuf #(
    parameter int DEPTH      = 4,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINE_SHIFT = 2
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         push_i,
    input  logic [ADDR_W-1:0]            push_addr_i,
    input  logic [DATA_W-1:0]            push_data_i,
    input  logic [DATA_W/8-1:0]          push_be_i,
    output logic                         full_o,
    output logic                         head_valid_o,
    output logic [ADDR_W-1:0]            head_addr_o,
    output logic [DATA_W-1:0]            head_data_o,
    output logic [DATA_W/8-1:0]          head_be_o,
    input  logic                         head_ready_i,
    input  logic [ADDR_W-LINE_SHIFT-1:0] probe_line_i,
    output logic                         conflict_o
);
    localparam int BE_W = DATA_W / 8;
    localparam int PW   = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [DEPTH-1:0][BE_W-1:0]   be;
        logic [PW-1:0]                rd_ptr;
        logic [PW-1:0]                wr_ptr;
    } wb_state_t;

    wb_state_t s_d, s_q;
    logic [DEPTH-1:0] line_hit;

    assign full_o       = s_q.vld[s_q.wr_ptr];
    assign head_valid_o = s_q.vld[s_q.rd_ptr];
    assign head_addr_o  = s_q.addr[s_q.rd_ptr];
    assign head_data_o  = s_q.data[s_q.rd_ptr];
    assign head_be_o    = s_q.be[s_q.rd_ptr];

    // One comparator per slot against the probed line address
    for (genvar g = 0; g < DEPTH; g++) begin : g_probe
        assign line_hit[g] = s_q.vld[g] &&
                             (s_q.addr[g][ADDR_W-1:LINE_SHIFT] == probe_line_i);
    end
    assign conflict_o = |line_hit;

    always_comb begin
        s_d = s_q;
        if (s_q.vld[s_q.rd_ptr] && head_ready_i) begin
            s_d.vld[s_q.rd_ptr] = 1'b0;
            s_d.rd_ptr          = s_q.rd_ptr + PW'(1);
        end
        if (push_i) begin
            s_d.vld[s_q.wr_ptr]  = 1'b1;
            s_d.addr[s_q.wr_ptr] = push_addr_i;
            s_d.data[s_q.wr_ptr] = push_data_i;
            s_d.be[s_q.wr_ptr]   = push_be_i;
            s_d.wr_ptr           = s_q.wr_ptr + PW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/wt_dcache_array.sv
`timescale 1ns/1ps
// Tag, valid and line storage with one combinational lookup port,
// a masked word-write port and a whole-line fill port.
module wt_dcache_array #(
    parameter int SETS       = 16,
    parameter int LINE_WORDS = 4,
    parameter int TAG_W      = 10,
    parameter int DATA_W     = 32
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [$clog2(SETS)-1:0]      lk_idx_i,
    output logic                         lk_valid_o,
    output logic [TAG_W-1:0]             lk_tag_o,
    output logic [LINE_WORDS*DATA_W-1:0] lk_line_o,
    input  logic                         wr_en_i,
    input  logic [$clog2(SETS)-1:0]      wr_idx_i,
    input  logic [$clog2(LINE_WORDS)-1:0] wr_off_i,
    input  logic [DATA_W-1:0]            wr_data_i,
    input  logic [DATA_W/8-1:0]          wr_be_i,
    input  logic                         fill_en_i,
    input  logic [$clog2(SETS)-1:0]      fill_idx_i,
    input  logic [TAG_W-1:0]             fill_tag_i,
    input  logic [LINE_WORDS*DATA_W-1:0] fill_line_i
);
    localparam int LINE_W = LINE_WORDS * DATA_W;
    localparam int BE_W   = DATA_W / 8;

    logic [SETS-1:0]   valid_d, valid_q;
    logic [LINE_W-1:0] line_mem [SETS];
    logic [TAG_W-1:0]  tag_mem  [SETS];

    assign lk_valid_o = valid_q[lk_idx_i];
    assign lk_tag_o   = tag_mem[lk_idx_i];
    assign lk_line_o  = line_mem[lk_idx_i];

    always_comb begin
        valid_d = valid_q;
        if (fill_en_i) begin
            valid_d[fill_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
    end

    // Storage without reset: contents are qualified by the valid bits
    always_ff @(posedge clk_i) begin
        if (fill_en_i) begin
            line_mem[fill_idx_i] <= fill_line_i;
            tag_mem[fill_idx_i]  <= fill_tag_i;
        end else if (wr_en_i) begin
            for (int b = 0; b < BE_W; b++) begin
                if (wr_be_i[b]) begin
                    line_mem[wr_idx_i][int'(wr_off_i) * DATA_W + b * 8 +: 8]
                        <= wr_data_i[b*8 +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/wt_dcache.sv
`timescale 1ns/1ps
// Direct-mapped write-through, no-write-allocate data cache with store queue.
module wt_dcache
    import wt_dcache_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SETS       = 16,
    parameter int WB_DEPTH   = 4
) (
    input  logic                                   clk_i,
    input  logic                                   rst_ni,
    input  logic                                   req_valid_i,
    input  logic                                   req_write_i,
    input  logic [ADDR_W-1:0]                      req_addr_i,
    input  logic [DATA_W-1:0]                      req_wdata_i,
    input  logic [DATA_W/8-1:0]                    req_be_i,
    output logic                                   req_ready_o,
    output logic                                   rsp_valid_o,
    output logic [DATA_W-1:0]                      rsp_rdata_o,
    output logic                                   mem_rd_valid_o,
    output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]   mem_rd_line_o,
    input  logic                                   mem_rd_ready_i,
    input  logic                                   mem_fill_valid_i,
    input  logic [LINE_WORDS*DATA_W-1:0]           mem_fill_data_i,
    output logic                                   mem_wr_valid_o,
    output logic [ADDR_W-1:0]                      mem_wr_addr_o,
    output logic [DATA_W-1:0]                      mem_wr_data_o,
    output logic [DATA_W/8-1:0]                    mem_wr_be_o,
    input  logic                                   mem_wr_ready_i
);
    localparam int OFF_W  = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = LINE_WORDS * DATA_W;

    typedef struct packed {
        ctl_state_e        st;
        logic [ADDR_W-1:0] maddr;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_d;
    } ctl_t;

    ctl_t c_d, c_q;

    // Address fields of the incoming request and of the pending miss
    logic [OFF_W-1:0] req_off;
    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    logic [OFF_W-1:0] miss_off;
    logic [IDX_W-1:0] miss_idx;
    logic [TAG_W-1:0] miss_tag;

    assign req_off  = req_addr_i[OFF_W-1:0];
    assign req_idx  = req_addr_i[OFF_W +: IDX_W];
    assign req_tag  = req_addr_i[ADDR_W-1 -: TAG_W];
    assign miss_off = c_q.maddr[OFF_W-1:0];
    assign miss_idx = c_q.maddr[OFF_W +: IDX_W];
    assign miss_tag = c_q.maddr[ADDR_W-1 -: TAG_W];

    // Array and queue hookup
    logic              lk_valid;
    logic [TAG_W-1:0]  lk_tag;
    logic [LINE_W-1:0] lk_line;
    logic              lk_hit;
    logic              accept;
    logic              store_push;
    logic              store_hit;
    logic              fill_en;
    logic              wb_full;
    logic              wb_conflict;

    wt_dcache_array #(
        .SETS       (SETS),
        .LINE_WORDS (LINE_WORDS),
        .TAG_W      (TAG_W),
        .DATA_W     (DATA_W)
    ) u_array (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .lk_idx_i    (req_idx),
        .lk_valid_o  (lk_valid),
        .lk_tag_o    (lk_tag),
        .lk_line_o   (lk_line),
        .wr_en_i     (store_hit),
        .wr_idx_i    (req_idx),
        .wr_off_i    (req_off),
        .wr_data_i   (req_wdata_i),
        .wr_be_i     (req_be_i),
        .fill_en_i   (fill_en),
        .fill_idx_i  (miss_idx),
        .fill_tag_i  (miss_tag),
        .fill_line_i (mem_fill_data_i)
    );

    wt_dcache_wbuf #(
        .DEPTH      (WB_DEPTH),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .LINE_SHIFT (OFF_W)
    ) u_wbuf (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .push_i       (store_push),
        .push_addr_i  (req_addr_i),
        .push_data_i  (req_wdata_i),
        .push_be_i    (req_be_i),
        .full_o       (wb_full),
        .head_valid_o (mem_wr_valid_o),
        .head_addr_o  (mem_wr_addr_o),
        .head_data_o  (mem_wr_data_o),
        .head_be_o    (mem_wr_be_o),
        .head_ready_i (mem_wr_ready_i),
        .probe_line_i (c_q.maddr[ADDR_W-1:OFF_W]),
        .conflict_o   (wb_conflict)
    );

    assign lk_hit      = lk_valid && (lk_tag == req_tag);
    assign req_ready_o = (c_q.st == CTL_IDLE) && !(req_write_i && wb_full);
    assign accept      = req_valid_i && req_ready_o;
    assign store_push  = accept && req_write_i;
    assign store_hit   = store_push && lk_hit;
    assign fill_en     = (c_q.st == CTL_FILL) && mem_fill_valid_i;

    // Fetch is held back while any queued store targets the missing line
    assign mem_rd_valid_o = (c_q.st == CTL_MISS) && !wb_conflict;
    assign mem_rd_line_o  = c_q.maddr[ADDR_W-1:OFF_W];
    assign rsp_valid_o    = c_q.rsp_v;
    assign rsp_rdata_o    = c_q.rsp_d;

    always_comb begin
        c_d       = c_q;
        c_d.rsp_v = 1'b0;
        unique case (c_q.st)
            CTL_IDLE: begin
                if (accept && !req_write_i) begin
                    if (lk_hit) begin
                        c_d.rsp_v = 1'b1;
                        c_d.rsp_d = lk_line[int'(req_off) * DATA_W +: DATA_W];
                    end else begin
                        c_d.st    = CTL_MISS;
                        c_d.maddr = req_addr_i;
                    end
                end
            end
            CTL_MISS: begin
                if (mem_rd_valid_o && mem_rd_ready_i) begin
                    c_d.st = CTL_FILL;
                end
            end
            CTL_FILL: begin
                if (mem_fill_valid_i) begin
                    c_d.st    = CTL_IDLE;
                    c_d.rsp_v = 1'b1;
                    c_d.rsp_d = mem_fill_data_i[int'(miss_off) * DATA_W +: DATA_W];
                end
            end
            default: c_d.st = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q <= '{st: CTL_IDLE, maddr: '0, rsp_v: 1'b0, rsp_d: '0};
        end else begin
            c_q <= c_d;
        end
    end

endmodule

// File: rtl/wt_dcache_chk.sv
`timescale 1ns/1ps
module wt_dcache_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LADR_W = 14
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                req_valid_i,
    input logic                req_write_i,
    input logic                req_ready_o,
    input logic                mem_rd_valid_o,
    input logic                mem_rd_ready_i,
    input logic [LADR_W-1:0]   mem_rd_line_o,
    input logic                mem_wr_valid_o,
    input logic                mem_wr_ready_i,
    input logic [ADDR_W-1:0]   mem_wr_addr_o,
    input logic [DATA_W-1:0]   mem_wr_data_o,
    input logic [DATA_W/8-1:0] mem_wr_be_o,
    input logic                wb_full,
    input logic                wb_conflict
);

    assert_rd_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_rd_valid_o && !mem_rd_ready_i |=> mem_rd_valid_o && $stable(mem_rd_line_o));

    assert_wr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_wr_valid_o && !mem_wr_ready_i |=> mem_wr_valid_o && $stable(mem_wr_addr_o)
            && $stable(mem_wr_data_o) && $stable(mem_wr_be_o));

    assert_full_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i && req_write_i && wb_full |-> !req_ready_o);

    assert_no_conflict_fetch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_rd_valid_o |-> !wb_conflict);

    assert_miss_blocks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_rd_valid_o |-> !req_ready_o);

endmodule

bind wt_dcache wt_dcache_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LADR_W (ADDR_W - $clog2(LINE_WORDS))
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_write_i    (req_write_i),
    .req_ready_o    (req_ready_o),
    .mem_rd_valid_o (mem_rd_valid_o),
    .mem_rd_ready_i (mem_rd_ready_i),
    .mem_rd_line_o  (mem_rd_line_o),
    .mem_wr_valid_o (mem_wr_valid_o),
    .mem_wr_ready_i (mem_wr_ready_i),
    .mem_wr_addr_o  (mem_wr_addr_o),
    .mem_wr_data_o  (mem_wr_data_o),
    .mem_wr_be_o    (mem_wr_be_o),
    .wb_full        (wb_full),
    .wb_conflict    (wb_conflict)
);

// File: tb/wt_dcache_tb.sv
`timescale 1ns/1ps
module wt_dcache_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [15:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [3:0]   req_be = '0;
    logic         req_ready;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic         mem_rd_valid;
    logic [13:0]  mem_rd_line;
    logic         mem_rd_ready = 1'b0;
    logic         mem_fill_valid = 1'b0;
    logic [127:0] mem_fill_data = '0;
    logic         mem_wr_valid;
    logic [15:0]  mem_wr_addr;
    logic [31:0]  mem_wr_data;
    logic [3:0]   mem_wr_be;
    logic         mem_wr_ready = 1'b0;

    always #10 clk = ~clk;

    wt_dcache u_dut (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .req_valid_i      (req_valid),
        .req_write_i      (req_write),
        .req_addr_i       (req_addr),
        .req_wdata_i      (req_wdata),
        .req_be_i         (req_be),
        .req_ready_o      (req_ready),
        .rsp_valid_o      (rsp_valid),
        .rsp_rdata_o      (rsp_rdata),
        .mem_rd_valid_o   (mem_rd_valid),
        .mem_rd_line_o    (mem_rd_line),
        .mem_rd_ready_i   (mem_rd_ready),
        .mem_fill_valid_i (mem_fill_valid),
        .mem_fill_data_i  (mem_fill_data),
        .mem_wr_valid_o   (mem_wr_valid),
        .mem_wr_addr_o    (mem_wr_addr),
        .mem_wr_data_o    (mem_wr_data),
        .mem_wr_be_o      (mem_wr_be),
        .mem_wr_ready_i   (mem_wr_ready)
    );

    typedef struct packed {
        logic [15:0] a;
        logic [31:0] d;
        logic [3:0]  be;
    } wr_t;

    int          n_tests = 0;
    int          n_fail = 0;
    logic [31:0] mem_model [256];
    logic [31:0] arch_mem  [256];
    wr_t         exp_q [$];
    int          rd_count = 0;
    logic [13:0] last_rd_line = '0;
    bit          fetch_bypassed = 0;
    bit          wr_block = 0;
    bit          wr_hold = 0;
    wr_t         wr_saved;
    bit          fill_pend = 0;
    int          fill_dly = 0;
    logic [5:0]  fill_line = '0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] init_word(input int i);
        logic [7:0] k = i[7:0];
        return {k ^ 8'h5A, k, 8'hC3, ~k};
    endfunction

    // Memory side: everything decided on falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                // Fill beat from an earlier accepted fetch
                mem_fill_valid = 1'b0;
                if (fill_pend) begin
                    if (fill_dly == 0) begin
                        for (int w = 0; w < 4; w++)
                            mem_fill_data[w*32 +: 32] = mem_model[{fill_line, w[1:0]}];
                        mem_fill_valid = 1'b1;
                        fill_pend = 0;
                    end else begin
                        fill_dly--;
                    end
                end
                // Write port: ready for the coming edge, then commit
                mem_wr_ready = !wr_block && ($urandom % 3 != 0);
                if (mem_wr_valid) begin
                    if (wr_hold)
                        check({mem_wr_addr, mem_wr_data, mem_wr_be} == wr_saved, "R10 write payload held",
                              {mem_wr_addr, 16'h0}, {wr_saved.a, 16'h0});
                    if (mem_wr_ready) begin
                        wr_hold = 0;
                        if (exp_q.size() == 0) begin
                            check(0, "R4 unexpected memory write", {16'h0, mem_wr_addr}, 32'h0);
                        end else begin
                            check(exp_q[0].a == mem_wr_addr && exp_q[0].d == mem_wr_data &&
                                  exp_q[0].be == mem_wr_be, "R4 write order/payload",
                                  {mem_wr_addr, 12'h0, mem_wr_be}, {exp_q[0].a, 12'h0, exp_q[0].be});
                            void'(exp_q.pop_front());
                        end
                        mem_model[mem_wr_addr[7:0]] =
                            merge(mem_model[mem_wr_addr[7:0]], mem_wr_data, mem_wr_be);
                    end else begin
                        wr_hold  = 1;
                        wr_saved = '{a: mem_wr_addr, d: mem_wr_data, be: mem_wr_be};
                    end
                end else if (wr_hold) begin
                    check(0, "R10 write valid dropped", 32'h0, 32'h1);
                    wr_hold = 0;
                end
                // Read port
                mem_rd_ready = !fill_pend && ($urandom % 2 == 0);
                if (mem_rd_valid && mem_rd_ready) begin
                    bit clash = 0;
                    foreach (exp_q[k]) if (exp_q[k].a[15:2] == mem_rd_line) clash = 1;
                    check(!clash, "R9 fetch passed a same-line store", {18'h0, mem_rd_line}, 32'h0);
                    if (exp_q.size() != 0) fetch_bypassed = 1;
                    rd_count++;
                    last_rd_line = mem_rd_line;
                    fill_line    = mem_rd_line[5:0];
                    fill_pend    = 1;
                    fill_dly     = $urandom % 3;
                end
            end
        end
    end

    task automatic wait_accept();
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic cpu_load(input int a, output logic [31:0] d, output int lat);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a[15:0];
        req_wdata = '0;   req_be = '0;
        wait_accept();
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        d = rsp_rdata;
    endtask

    task automatic cpu_store(input int a, input logic [31:0] d, input logic [3:0] be);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a[15:0];
        req_wdata = d;    req_be = be;
        wait_accept();
        arch_mem[a[7:0]] = merge(arch_mem[a[7:0]], d, be);
        exp_q.push_back('{a: a[15:0], d: d, be: be});
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic load_chk(input int a, input string tag, output int lat);
        logic [31:0] d;
        logic [31:0] e = arch_mem[a[7:0]];
        cpu_load(a, d, lat);
        check(d === e, tag, d, e);
    endtask

    task automatic wait_drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        int lat;
        int rc;
        for (int i = 0; i < 256; i++) begin
            mem_model[i] = init_word(i);
            arch_mem[i]  = init_word(i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        check(req_ready === 1'b1, "R1 ready after reset", {31'h0, req_ready}, 32'h1);
        check(mem_wr_valid === 1'b0 && mem_rd_valid === 1'b0 && rsp_valid === 1'b0,
              "R1 idle memory ports", {29'h0, mem_wr_valid, mem_rd_valid, rsp_valid}, 32'h0);
        @(negedge clk);

        // R1/R3: first load misses and fetches line 4
        rc = rd_count;
        load_chk(16'h10, "R3 refill data", lat);
        check(rd_count == rc + 1, "R1 first load misses", rd_count, rc + 1);
        check(last_rd_line == 14'h4, "R3 fetch line address", {18'h0, last_rd_line}, 32'h4);
        // R2: same word hits, R3: other word of line hits
        rc = rd_count;
        load_chk(16'h10, "R2 hit data", lat);
        check(lat == 0 && rd_count == rc, "R2 hit latency", lat, 0);
        load_chk(16'h13, "R3 line word data", lat);
        check(lat == 0 && rd_count == rc, "R3 whole line installed", lat, 0);

        // R5: store hit merges under byte enables
        cpu_store(16'h11, 32'hDEADBEEF, 4'b0101);
        rc = rd_count;
        load_chk(16'h11, "R5 merged store hit", lat);
        check(rd_count == rc && lat == 0, "R5 no fetch after store hit", rd_count, rc);

        // R6: store miss does not allocate
        cpu_store(16'h40, 32'h12345678, 4'b1111);
        wait_drain();
        rc = rd_count;
        load_chk(16'h40, "R6 memory got store", lat);
        check(rd_count == rc + 1, "R6 no allocate on store miss", rd_count, rc + 1);

        // R2: tag mismatch in occupied set misses
        rc = rd_count;
        load_chk(16'h50, "R2 tag mismatch data", lat);
        check(rd_count == rc + 1, "R2 tag mismatch misses", rd_count, rc + 1);
        load_chk(16'h10, "R2 evicted line data", lat);
        check(rd_count == rc + 2, "R2 evicted line misses", rd_count, rc + 2);

        // R7: four queued stores fill the buffer, fifth stalls
        wait_drain();
        wr_block = 1;
        @(negedge clk);
        for (int k = 0; k < 4; k++) cpu_store(16'h20 + k * 4, 32'hA0 + k, 4'hF);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h30;
        req_wdata = 32'h5555AAAA; req_be = 4'hF;
        for (int k = 0; k < 3; k++) begin
            #1;
            check(req_ready === 1'b0, "R7 full queue stalls store", {31'h0, req_ready}, 32'h0);
            @(negedge clk);
        end
        wr_block = 0;
        cpu_store(16'h30, 32'h5555AAAA, 4'hF);
        wait_drain();

        // R8: miss to an unrelated line bypasses a queued store
        wr_block = 1;
        @(negedge clk);
        fetch_bypassed = 0;
        cpu_store(16'h80, 32'hCAFE0001, 4'hF);
        load_chk(16'hC4, "R8 bypass load data", lat);
        check(fetch_bypassed == 1, "R8 fetch ahead of queued store", {31'h0, fetch_bypassed}, 32'h1);
        wr_block = 0;
        wait_drain();

        // R9/R11: miss to a line with a queued store waits for drain
        wr_block = 1;
        @(negedge clk);
        cpu_store(16'hE0, 32'h0BADF00D, 4'b1100);
        rc = rd_count;
        fork
            load_chk(16'hE0, "R9 load sees drained store", lat);
            begin
                for (int k = 0; k < 8; k++) begin
                    @(negedge clk);
                    #1;
                    check(mem_rd_valid === 1'b0, "R9 fetch held by conflict",
                          {31'h0, mem_rd_valid}, 32'h0);
                    check(req_ready === 1'b0, "R11 port held during miss",
                          {31'h0, req_ready}, 32'h0);
                end
                check(rd_count == rc, "R9 no fetch while conflicting", rd_count, rc);
                wr_block = 0;
            end
        join
        check(rd_count == rc + 1, "R9 fetch after drain", rd_count, rc + 1);

        // Random traffic with random memory back-pressure
        for (int n = 0; n < 2500; n++) begin
            int a = $urandom % 256;
            if ($urandom % 2 == 0) begin
                logic [3:0] be = 4'($urandom % 15 + 1);
                cpu_store(a, $urandom, be);
            end else begin
                load_chk(a, "R3 R5 random load data", lat);
            end
        end
        wait_drain();
        check(exp_q.size() == 0, "R4 all stores drained", exp_q.size(), 0);
        begin
            int bad = 0;
            for (int i = 0; i < 256; i++) if (mem_model[i] !== arch_mem[i]) bad++;
            check(bad == 0, "R4 memory matches store history", bad, 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule